// File: doc/BRIEF.md
# Tile-Mapped Pixel Colour Generator

This block turns a stream of screen coordinates into a 3-bit colour (one bit each for red, green and blue) for a 640x480 raster. Instead of holding a colour for every pixel, it views the screen as an 80 by 60 grid of 8x8-pixel cells. A cell memory keeps a 5-bit glyph number per cell, and a glyph memory keeps 32 monochrome 8x8 bitmaps. Each pixel is resolved by two reads: the cell it falls in gives a glyph number, and the glyph row picked by the pixel's line gives eight bits, of which the pixel's column picks one. A set bit shows the foreground colour, a clear bit the background colour. Both colours are inputs.

The coordinates, the active-video flag and a pixel-enable strobe come from an external raster timing generator. A host port writes either memory on any clock without holding up the read path. Both memories read synchronously. The active-video flag and the in-cell column travel through the same pipeline stages as the reads, so each colour is matched to the pixel that asked for it. A delayed copy of the active-video flag is also brought out.

Top module: `tile_pixgen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `rgb` is 000 and `video_on_q` is 0.
- R2: A pixel presented with `video_on` low yields `rgb` = 000, whatever the memories and colour inputs hold.
- R3: The cell read for a pixel sits at cell address (pixel_y >> 3) * 80 + (pixel_x >> 3).
- R4: Within the glyph, row pixel_y[2:0] is read, and pixel_x[2:0] selects the bit: column 0 is bit 7 and column 7 is bit 0.
- R5: A set glyph bit yields `fg_color` and a clear bit yields `bg_color`, each sampled when the output register loads.
- R6: A pixel sampled on pixel strobe n appears on `rgb` right after strobe n+2, i.e. the third strobe edge including its own. While `pix_tick` is low, `rgb` and `video_on_q` hold their values.
- R7: A host write with `host_sel` = 0 stores `host_data[4:0]` as the glyph number of cell `host_addr`.
- R8: A host write with `host_sel` = 1 stores `host_data[7:0]` as glyph row `host_addr[7:0]`, where that address is glyph number * 8 + row.
- R9: A host write issued while a pixel is in flight does not change that pixel's result once its cell has already been read. Host writes never stall the pixel pipeline.
- R10: Reset clears both memories, so every pixel shows `bg_color` until the host writes something.
- R11: `video_on_q` equals `video_on` delayed by three pixel strobes, and it is aligned with `rgb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_tick | input | 1 | Pixel enable strobe; the pipeline advances only when it is high |
| video_on | input | 1 | Active-video flag for the current coordinates |
| pixel_x | input | 10 | Horizontal coordinate, 0 to 639 |
| pixel_y | input | 10 | Vertical coordinate, 0 to 479 |
| fg_color | input | 3 | Colour shown for set glyph bits |
| bg_color | input | 3 | Colour shown for clear glyph bits |
| host_we | input | 1 | Host write strobe, one write per clock |
| host_sel | input | 1 | Target memory: 0 cell memory, 1 glyph memory |
| host_addr | input | 13 | Cell address, or glyph row address in bits 7:0 |
| host_data | input | 8 | Glyph number in bits 4:0, or an 8-bit glyph row |
| rgb | output | 3 | Pipelined pixel colour |
| video_on_q | output | 1 | `video_on` delayed to line up with `rgb` |

## Verification
The assertions assume that `pix_tick` is a plain enable with no fixed cadence, and that `video_on` and the coordinates change only between strobes. They also assume that reset is held for at least one clock before the first strobe. The bench drives all inputs on falling clock edges and gives each strobe exactly one rising edge, so every pipeline step can be pointed to. Coordinates stay inside the visible area. Host writes fall between strobes, and one of them lands on purpose while a pixel is between its two reads.

// File: rtl/tpg_pkg.sv
// Shared definitions for the tile-mapped pixel generator.
// Assumes square cells whose side is a power of two (8 pixels).
package tpg_pkg;
    localparam int CELL_SHIFT = 3;
    localparam int CELL_PX    = 1 << CELL_SHIFT;
    localparam int RGB_W      = 3;

    typedef logic [RGB_W-1:0] rgb_t;

    typedef enum logic {
        MEM_CELL  = 1'b0,
        MEM_GLYPH = 1'b1
    } mem_sel_e;
endpackage

// File: rtl/tpg_addr_map.sv
// Combinational cell-address mapper.
// Converts a pixel coordinate to a linear cell index row*COLS+col,
// plus the row and column inside the cell.
// Assumes COORD_W is wide enough for the screen and that TADDR_W holds COLS*ROWS-1.
module tpg_addr_map
    import tpg_pkg::*;
#(
    parameter int COLS    = 80,
    parameter int COORD_W = 10,
    parameter int TADDR_W = 13
) (
    input  logic [COORD_W-1:0]    pixel_x,
    input  logic [COORD_W-1:0]    pixel_y,
    output logic [TADDR_W-1:0]    cell_addr,
    output logic [CELL_SHIFT-1:0] in_row,
    output logic [CELL_SHIFT-1:0] in_col
);
    logic [TADDR_W-1:0] row_w;
    logic [TADDR_W-1:0] col_w;

    // Split the coordinates into a cell index and an offset inside the cell.
    always_comb begin
        row_w     = TADDR_W'(pixel_y[COORD_W-1:CELL_SHIFT]);
        col_w     = TADDR_W'(pixel_x[COORD_W-1:CELL_SHIFT]);
        cell_addr = row_w * TADDR_W'(COLS) + col_w;
        in_row    = pixel_y[CELL_SHIFT-1:0];
        in_col    = pixel_x[CELL_SHIFT-1:0];
    end
endmodule

// File: rtl/tpg_sync_ram.sv
// Simple dual-port memory: one write port, one synchronous read port.
// The read updates only when rd_en is high. A read and a write to the same
// address in one cycle return the old data. Out-of-range addresses are ignored
// on write and read back as zero. A synchronous reset clears every entry.
module tpg_sync_ram #(
    parameter int DEPTH  = 256,
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Storage array: cleared on reset, written from the host side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && (32'(wr_addr) < DEPTH)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read port, advanced by the pixel strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= (32'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
    end
endmodule

// File: rtl/tpg_color_out.sv
// Final stage: picks one bit of the glyph row and turns it into a colour.
// The output is forced to blank when the delayed active-video flag is low.
// Assumes column 0 of a cell maps to the most significant bit of the row.
module tpg_color_out
    import tpg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  logic                  vid_in,
    input  logic [CELL_SHIFT-1:0] col_in,
    input  logic [CELL_PX-1:0]    row_bits,
    input  rgb_t                  fg_color,
    input  rgb_t                  bg_color,
    output rgb_t                  rgb,
    output logic                  vid_out
);
    logic lit;

    // Column 0 is the MSB, so the bit index is the bitwise complement of the column.
    always_comb lit = row_bits[~col_in];

    // Output register: colour or blank, plus the aligned video flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb     <= '0;
            vid_out <= 1'b0;
        end else if (adv) begin
            rgb     <= vid_in ? (lit ? fg_color : bg_color) : '0;
            vid_out <= vid_in;
        end
    end
endmodule

// File: rtl/tile_pixgen.sv
// Tile-mapped pixel colour generator.
// Three pixel-strobe stages: cell read, glyph read, colour select.
// The video flag and the cell offsets travel with the reads, so each colour
// stays matched to its pixel. Host writes go to either memory on any clock
// and never stall the pipeline.
// Assumes the coordinates and video_on change only between strobes.
module tile_pixgen
    import tpg_pkg::*;
#(
    parameter  int COLS     = 80,
    parameter  int ROWS     = 60,
    parameter  int GLYPHS   = 32,
    parameter  int COORD_W  = 10,
    localparam int IDX_W    = $clog2(GLYPHS),
    localparam int TADDR_W  = $clog2(COLS * ROWS),
    localparam int GADDR_W  = IDX_W + CELL_SHIFT,
    localparam int HADDR_W  = (TADDR_W > GADDR_W) ? TADDR_W : GADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_tick,
    input  logic               video_on,
    input  logic [COORD_W-1:0] pixel_x,
    input  logic [COORD_W-1:0] pixel_y,
    input  logic [RGB_W-1:0]   fg_color,
    input  logic [RGB_W-1:0]   bg_color,
    input  logic               host_we,
    input  logic               host_sel,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [CELL_PX-1:0] host_data,
    output logic [RGB_W-1:0]   rgb,
    output logic               video_on_q
);
    logic [TADDR_W-1:0]    cell_addr;
    logic [CELL_SHIFT-1:0] row0, col0;
    logic [IDX_W-1:0]      glyph_idx;
    logic [CELL_PX-1:0]    glyph_row;
    logic                  vid1, vid2;
    logic [CELL_SHIFT-1:0] row1, col1, col2;
    logic                  we_cell, we_glyph;

    // Route the host write strobe to the selected memory.
    always_comb begin
        we_cell  = host_we && (mem_sel_e'(host_sel) == MEM_CELL);
        we_glyph = host_we && (mem_sel_e'(host_sel) == MEM_GLYPH);
    end

    tpg_addr_map #(
        .COLS    (COLS),
        .COORD_W (COORD_W),
        .TADDR_W (TADDR_W)
    ) u_map (
        .pixel_x   (pixel_x),
        .pixel_y   (pixel_y),
        .cell_addr (cell_addr),
        .in_row    (row0),
        .in_col    (col0)
    );

    // Stage 1: cell memory read.
    tpg_sync_ram #(
        .DEPTH  (COLS * ROWS),
        .WIDTH  (IDX_W),
        .ADDR_W (TADDR_W)
    ) u_cell_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (we_cell),
        .wr_addr (host_addr[TADDR_W-1:0]),
        .wr_data (host_data[IDX_W-1:0]),
        .rd_en   (pix_tick),
        .rd_addr (cell_addr),
        .rd_data (glyph_idx)
    );

    // Stage 1 side band: carry the video flag and the in-cell offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid1 <= 1'b0;
            row1 <= '0;
            col1 <= '0;
        end else if (pix_tick) begin
            vid1 <= video_on;
            row1 <= row0;
            col1 <= col0;
        end
    end

    // Stage 2: glyph memory read, addressed by {glyph number, row}.
    tpg_sync_ram #(
        .DEPTH  (GLYPHS * CELL_PX),
        .WIDTH  (CELL_PX),
        .ADDR_W (GADDR_W)
    ) u_glyph_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (we_glyph),
        .wr_addr (host_addr[GADDR_W-1:0]),
        .wr_data (host_data),
        .rd_en   (pix_tick),
        .rd_addr ({glyph_idx, row1}),
        .rd_data (glyph_row)
    );

    // Stage 2 side band: carry the video flag and the column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid2 <= 1'b0;
            col2 <= '0;
        end else if (pix_tick) begin
            vid2 <= vid1;
            col2 <= col1;
        end
    end

    // Stage 3: colour selection and blanking.
    tpg_color_out u_color (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (pix_tick),
        .vid_in   (vid2),
        .col_in   (col2),
        .row_bits (glyph_row),
        .fg_color (fg_color),
        .bg_color (bg_color),
        .rgb      (rgb),
        .vid_out  (video_on_q)
    );
endmodule

// File: rtl/tpg_checker.sv
// Assertion checker for tile_pixgen, bound to the top module.
// Keeps an independent three-strobe history of video_on to check alignment.
module tpg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pix_tick,
    input logic       video_on,
    input logic [2:0] rgb,
    input logic       video_on_q
);
    logic [2:0] vid_hist;

    // Reference history of the active-video flag, shifted on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vid_hist <= '0;
        else if (pix_tick)
            vid_hist <= {vid_hist[1:0], video_on};
    end

    AST_RESET_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rgb == 3'b000 && !video_on_q));              // R1

    AST_BLANK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !video_on_q |-> (rgb == 3'b000));                               // R2

    AST_VIDEO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        video_on_q == vid_hist[2]);                                     // R11

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pix_tick)) |-> ($stable(rgb) && $stable(video_on_q))); // R6
endmodule

bind tile_pixgen tpg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_tick   (pix_tick),
    .video_on   (video_on),
    .rgb        (rgb),
    .video_on_q (video_on_q)
);

// File: tb/tile_pixgen_tb.sv
module tile_pixgen_tb;
    localparam real HALF = 2.5;   // 200 MHz clock

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_tick = 1'b0;
    logic        video_on = 1'b0;
    logic [9:0]  pixel_x = '0, pixel_y = '0;
    logic [2:0]  fg_color = 3'b110, bg_color = 3'b001;
    logic        host_we = 1'b0, host_sel = 1'b0;
    logic [12:0] host_addr = '0;
    logic [7:0]  host_data = '0;
    logic [2:0]  rgb;
    logic        video_on_q;

    int checks = 0;
    int errors = 0;

    always #(HALF) clk = ~clk;

    tile_pixgen u_dut (
        .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .video_on(video_on),
        .pixel_x(pixel_x), .pixel_y(pixel_y), .fg_color(fg_color), .bg_color(bg_color),
        .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr), .host_data(host_data),
        .rgb(rgb), .video_on_q(video_on_q)
    );

    // Vector: {x[9:0], y[9:0], video_on, expected rgb} with fg=110, bg=001.
    localparam logic [23:0] VEC [13] = '{
        {10'd40,  10'd16,  1'b1, 3'b110},  // R3 R4 cell(5,2) glyph2 r0 c0 set
        {10'd43,  10'd19,  1'b1, 3'b110},  // R4 r3 c3 set
        {10'd44,  10'd19,  1'b1, 3'b001},  // R4 r3 c4 clear
        {10'd47,  10'd23,  1'b1, 3'b110},  // R4 r7 c7 set
        {10'd48,  10'd16,  1'b1, 3'b001},  // R3 neighbour cell, glyph0
        {10'd40,  10'd24,  1'b1, 3'b001},  // R3 cell below, glyph0
        {10'd639, 10'd479, 1'b1, 3'b110},  // R3 last cell, glyph1
        {10'd632, 10'd472, 1'b1, 3'b110},  // R3 last cell corner
        {10'd631, 10'd479, 1'b1, 3'b001},  // R3 cell left of last
        {10'd639, 10'd479, 1'b0, 3'b000},  // R2 blank despite set bit
        {10'd0,   10'd0,   1'b1, 3'b110},  // R4 glyph3 r0 c0
        {10'd1,   10'd0,   1'b1, 3'b001},  // R4 glyph3 r0 c1
        {10'd6,   10'd2,   1'b1, 3'b110}   // R4 glyph3 r2 c6
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One strobe: exactly one rising edge sees pix_tick high.
    task automatic do_tick();
        @(negedge clk) pix_tick = 1'b1;
        @(negedge clk) pix_tick = 1'b0;
    endtask

    task automatic set_pix(input int x, input int y, input logic v);
        @(negedge clk);
        pixel_x = 10'(x); pixel_y = 10'(y); video_on = v;
    endtask

    task automatic host_wr(input logic sel, input int addr, input logic [7:0] data);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_addr = 13'(addr); host_data = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic probe(input string tag, input int x, input int y, input logic v,
                         input logic [2:0] exp);
        set_pix(x, y, v);
        repeat (3) do_tick();
        chk(tag, {1'b0, rgb}, {1'b0, exp});
    endtask

    function automatic logic [7:0] glyph_row(input int g, input int r);
        case (g)
            1:       return 8'hFF;
            2:       return 8'h80 >> r;
            3:       return 8'hA5 ^ 8'(r);
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 rgb in reset", {1'b0, rgb}, 4'b0000);
        chk("R1 video_on_q in reset", {3'b0, video_on_q}, 4'b0000);
        @(negedge clk) rst_n = 1'b1;
        chk("R1 rgb after reset", {1'b0, rgb}, 4'b0000);

        // R10: memories empty after reset -> background
        probe("R10 cleared memories", 0, 0, 1'b1, 3'b001);

        // R7 / R8: load cells and glyphs
        host_wr(1'b0, 2*80+5, 8'd2);
        host_wr(1'b0, 59*80+79, 8'd1);
        host_wr(1'b0, 0, 8'd3);
        for (int g = 1; g <= 3; g++)
            for (int r = 0; r < 8; r++)
                host_wr(1'b1, g*8 + r, glyph_row(g, r));

        // Table walk: R2 R3 R4 R5 R7 R8
        for (int i = 0; i < 13; i++)
            probe($sformatf("R3/R4 vector %0d", i), int'(VEC[i][23:14]), int'(VEC[i][13:4]),
                  VEC[i][3], VEC[i][2:0]);

        // R6 / R11: latency of three strobes
        probe("R2 prime blank", 2, 0, 1'b0, 3'b000);
        set_pix(0, 0, 1'b1); do_tick();
        set_pix(1, 0, 1'b1); do_tick();
        chk("R6 not yet after two strobes", {1'b0, rgb}, 4'b0000);
        set_pix(2, 0, 1'b0); do_tick();
        chk("R6 first pixel on third strobe", {1'b0, rgb}, 4'b0110);
        chk("R11 video_on_q aligned", {3'b0, video_on_q}, 4'b0001);
        do_tick();
        chk("R6 second pixel", {1'b0, rgb}, 4'b0001);
        do_tick();
        chk("R2 blank pixel", {1'b0, rgb}, 4'b0000);
        chk("R11 video_on_q low", {3'b0, video_on_q}, 4'b0000);

        // R6: hold while no strobe
        probe("R6 setup", 0, 0, 1'b1, 3'b110);
        set_pix(1, 0, 1'b1);
        repeat (6) @(negedge clk);
        chk("R6 hold without strobe", {1'b0, rgb}, 4'b0110);

        // R9: write lands between the cell read and the glyph read
        set_pix(43, 19, 1'b1); do_tick();
        host_wr(1'b0, 2*80+5, 8'd0);
        do_tick(); do_tick();
        chk("R9 in-flight pixel unaffected", {1'b0, rgb}, 4'b0110);
        probe("R7 cell rewrite took effect", 43, 19, 1'b1, 3'b001);

        // R8: glyph 0 row 0 bit 0 is column 7
        host_wr(1'b1, 0, 8'h01);
        probe("R8 glyph row write col7", 631, 472, 1'b1, 3'b110);
        probe("R4 col6 still clear", 630, 472, 1'b1, 3'b001);

        // R5: colour inputs
        fg_color = 3'b011; bg_color = 3'b100;
        probe("R5 new foreground", 631, 472, 1'b1, 3'b011);
        probe("R5 new background", 630, 472, 1'b1, 3'b100);

        // R1 / R10: reset mid-run clears output and memories
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rgb mid-run reset", {1'b0, rgb}, 4'b0000);
        chk("R1 video_on_q mid-run reset", {3'b0, video_on_q}, 4'b0000);
        @(negedge clk) rst_n = 1'b1;
        probe("R10 memories cleared again", 0, 0, 1'b1, 3'b100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(HALF * 2 * 200000);
        checks++; errors++;
        $display("FAIL R6 watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule